// File: doc/BRIEF.md
# Multi-mode 8x8 hardware multiplier

This block multiplies two 8-bit operands and delivers a 16-bit product split into a high byte (the R1 register of the destination pair) and a low byte (R0). A 3-bit mode select picks how the operands are read: both unsigned, both signed, or first operand signed and second operand unsigned. A separate fractional mode bit shifts the product left by one bit, which suits 1.7 fixed-point arithmetic.

A request is a one-cycle `start` strobe with the operands and mode present in the same cycle. The result, the zero flag and the carry flag are updated together two cycles later, and `done` pulses for that one cycle. The outputs then hold until the next result. A `start` that arrives while a request is in flight is dropped. The block produces only Z and C; the caller keeps every other status flag unchanged.

Top module: `mul8_unit`

## Requirements
- R1: With mode[1:0] = 2'b00 both operands are unsigned and {prod_hi, prod_lo} is the 16-bit product op_a * op_b.
- R2: With mode[1:0] = 2'b01 both operands are two's-complement signed and {prod_hi, prod_lo} is the low 16 bits of the signed product.
- R3: With mode[1:0] = 2'b10 op_a is signed and op_b is unsigned, and {prod_hi, prod_lo} is the low 16 bits of that mixed product.
- R4: With mode[2] = 1 the result is the product selected by mode[1:0] shifted left by one bit, with bit 0 cleared and the old bit 15 dropped.
- R5: mode[1:0] = 2'b11 is reserved and behaves as unsigned by unsigned (R1), with or without the fractional shift.
- R6: flag_c equals bit 15 of the product before any fractional shift.
- R7: flag_z is 1 exactly when the final 16-bit result {prod_hi, prod_lo} is zero.
- R8: done is 1 for exactly one cycle, the second cycle after the cycle in which start is accepted; result and flags change in that same cycle.
- R9: A start that arrives in the cycle right after an accepted start is ignored: it yields no done and no result.
- R10: prod_hi, prod_lo, flag_z and flag_c hold their values in every cycle where done is 0.
- R11: While rst is high and after it falls, done, prod_hi, prod_lo, flag_z and flag_c are 0 until the first result.
- R12: Signed fractional 0x80 by 0x80 gives 0x8000 with flag_c = 0 and flag_z = 0; there is no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, samples operands and mode |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| mode | input | 3 | bit 2 fractional; bits 1:0 00 unsigned, 01 signed, 10 signed by unsigned, 11 reserved (unsigned) |
| prod_hi | output | 8 | High byte of the result (R1) |
| prod_lo | output | 8 | Low byte of the result (R0) |
| done | output | 1 | One-cycle pulse when a result is written |
| flag_z | output | 1 | Zero flag of the final result |
| flag_c | output | 1 | Bit 15 of the unshifted product |

## Verification
The assertions watch, on every cycle, the timing contract: done follows an accepted start by exactly two cycles and lasts one, the in-flight state never lasts past one cycle so a second start is dropped, the outputs stay frozen between results, Z agrees with the written result and a fractional result always has a cleared bit 0. The arithmetic itself, the sign reading of each mode, the reserved mode, the carry taken before the shift and the 0x80 by 0x80 wrap are only shown by the bench, which sweeps every first operand against a set of edge and spread second operands in all eight mode codes and compares against products computed in integer arithmetic.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

  localparam int MODE_W = 3;

  // Sign reading of the operands, taken from mode[1:0]
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_RSV = 2'b11
  } sign_mode_e;

  function automatic logic frac_bit(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction

  function automatic logic a_is_signed(input logic [MODE_W-1:0] m);
    sign_mode_e s;
    s = sign_mode_e'(m[1:0]);
    return (s == SGN_SS) || (s == SGN_SU);
  endfunction

  function automatic logic b_is_signed(input logic [MODE_W-1:0] m);
    sign_mode_e s;
    s = sign_mode_e'(m[1:0]);
    return (s == SGN_SS);
  endfunction

endpackage

// File: rtl/mul8_issue.sv
// First stage: accepts a request when idle, sign-extends the operands
// by one bit according to the mode and holds them for the datapath.
module mul8_issue
  import mul8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [W-1:0]        op_a,
  input  logic [W-1:0]        op_b,
  input  logic [MODE_W-1:0]   mode,
  output logic                busy,
  output logic signed [W:0]   a_x,
  output logic signed [W:0]   b_x,
  output logic                frac_q
);

  localparam int NOPS = 2;

  logic                accept;
  logic [W-1:0]        raw   [NOPS];
  logic                sgn   [NOPS];
  logic signed [W:0]   ext_d [NOPS];
  logic signed [W:0]   ext_q [NOPS];

  assign accept = start & ~busy;

  assign raw[0] = op_a;
  assign raw[1] = op_b;
  assign sgn[0] = a_is_signed(mode);
  assign sgn[1] = b_is_signed(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      frac_q <= 1'b0;
    end else begin
      busy <= accept;
      if (accept) frac_q <= frac_bit(mode);
    end
  end

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    assign ext_d[i] = {sgn[i] & raw[i][W-1], raw[i]};
    always_ff @(posedge clk) begin
      if (rst) ext_q[i] <= '0;
      else if (accept) ext_q[i] <= ext_d[i];
    end
  end

  assign a_x = ext_q[0];
  assign b_x = ext_q[1];

endmodule

// File: rtl/mul8_datapath.sv
// Combinational product, optional fractional shift and flag derivation.
module mul8_datapath #(
  parameter int W = 8
) (
  input  logic signed [W:0]   a_x,
  input  logic signed [W:0]   b_x,
  input  logic                frac,
  output logic [2*W-1:0]      res,
  output logic                z,
  output logic                c
);

  localparam int PW = 2 * W;
  localparam int FW = 2 * W + 2;

  logic signed [FW-1:0] ea;
  logic signed [FW-1:0] eb;
  logic signed [FW-1:0] full;
  logic [PW-1:0]        raw;

  assign ea   = {{(W+1){a_x[W]}}, a_x};
  assign eb   = {{(W+1){b_x[W]}}, b_x};
  assign full = ea * eb;
  assign raw  = full[PW-1:0];

  always_comb begin
    if (frac) res = {raw[PW-2:0], 1'b0};
    else      res = raw;
  end

  assign c = raw[PW-1];
  assign z = (res == '0);

endmodule

// File: rtl/mul8_retire.sv
// Second stage: registers the result pair, the flags and the done pulse.
module mul8_retire #(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic [2*W-1:0]  res,
  input  logic            z,
  input  logic            c,
  output logic [W-1:0]    hi_q,
  output logic [W-1:0]    lo_q,
  output logic            z_q,
  output logic            c_q,
  output logic            done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= vld;
      if (vld) begin
        hi_q <= res[2*W-1:W];
        lo_q <= res[W-1:0];
        z_q  <= z;
        c_q  <= c;
      end
    end
  end

endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
  import mul8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [MODE_W-1:0] mode,
  output logic [W-1:0]      prod_hi,
  output logic [W-1:0]      prod_lo,
  output logic              done,
  output logic              flag_z,
  output logic              flag_c
);

  logic              busy;
  logic signed [W:0] a_x;
  logic signed [W:0] b_x;
  logic              frac_q;
  logic [2*W-1:0]    res;
  logic              z_d;
  logic              c_d;

  mul8_issue #(.W(W)) u_issue (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .mode   (mode),
    .busy   (busy),
    .a_x    (a_x),
    .b_x    (b_x),
    .frac_q (frac_q)
  );

  mul8_datapath #(.W(W)) u_dp (
    .a_x  (a_x),
    .b_x  (b_x),
    .frac (frac_q),
    .res  (res),
    .z    (z_d),
    .c    (c_d)
  );

  mul8_retire #(.W(W)) u_ret (
    .clk    (clk),
    .rst    (rst),
    .vld    (busy),
    .res    (res),
    .z      (z_d),
    .c      (c_d),
    .hi_q   (prod_hi),
    .lo_q   (prod_lo),
    .z_q    (flag_z),
    .c_q    (flag_c),
    .done_q (done)
  );

endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2:0]   mode,
  input logic         busy,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo,
  input logic         done,
  input logic         flag_z,
  input logic         flag_c
);

  AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> ##1 done); // R8

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({prod_hi, prod_lo, flag_z, flag_c})); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_z == ({prod_hi, prod_lo} == '0))); // R7

  AST_FRAC_LSB: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode[2]) |=> ##1 !prod_lo[0]); // R4

endmodule

bind mul8_unit mul8_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mode    (mode),
  .busy    (busy),
  .prod_hi (prod_hi),
  .prod_lo (prod_lo),
  .done    (done),
  .flag_z  (flag_z),
  .flag_c  (flag_c)
);

// File: tb/sim_mul8_unit.sv
`timescale 1ns/1ps
module sim_mul8_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic [2:0] mode = '0;
  logic [7:0] prod_hi, prod_lo;
  logic       done, flag_z, flag_c;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mul8_unit #(.W(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .mode(mode), .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result from the requirement text (R1..R6, R7)
  task automatic model(input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] m, output logic [15:0] r,
                       output logic z, output logic c);
    int av, bv, p;
    logic [15:0] raw;
    av = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    bv = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = av * bv;
    raw = p[15:0];
    c = raw[15];
    r = m[2] ? {raw[14:0], 1'b0} : raw;
    z = (r == 16'h0000);
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m[1:0])
      2'b00:   return m[2] ? "R1/R4" : "R1";
      2'b01:   return m[2] ? "R2/R4" : "R2";
      2'b10:   return m[2] ? "R3/R4" : "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] m);
    logic [15:0] er;
    logic ez, ec;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; mode = m;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 early", {31'd0, done}, 32'd0);
    @(negedge clk);
    model(a, b, m, er, ez, ec);
    check(done == 1'b1, "R8 done", {31'd0, done}, 32'd1);
    check({prod_hi, prod_lo} == er, req_of(m), {16'd0, prod_hi, prod_lo}, {16'd0, er});
    check(flag_c == ec, "R6", {31'd0, flag_c}, {31'd0, ec});
    check(flag_z == ez, "R7", {31'd0, flag_z}, {31'd0, ez});
  endtask

  function automatic logic [7:0] bpick(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'h81;
      5: return 8'hFF;
      default: return 8'((k * 37 + 5) & 8'hFF);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state while rst high
    check({done, flag_z, flag_c, prod_hi, prod_lo} == '0, "R11 in reset",
          {13'd0, done, flag_z, flag_c, prod_hi, prod_lo}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({done, flag_z, flag_c, prod_hi, prod_lo} == '0, "R11 after reset",
          {13'd0, done, flag_z, flag_c, prod_hi, prod_lo}, 32'd0);

    // R12: signed fractional wrap
    run_op(8'h80, 8'h80, 3'b101);
    check({prod_hi, prod_lo} == 16'h8000 && !flag_c && !flag_z, "R12",
          {13'd0, flag_z, flag_c, 1'b0, prod_hi, prod_lo}, 32'h0000_8000);

    // R8 and R10: done drops after one cycle and outputs hold
    run_op(8'h12, 8'h34, 3'b000);
    @(negedge clk);
    check(done == 1'b0, "R8 pulse", {31'd0, done}, 32'd0);
    check({prod_hi, prod_lo} == 16'h03A8, "R10 hold", {16'd0, prod_hi, prod_lo}, 32'h03A8);
    repeat (3) @(negedge clk);
    check({prod_hi, prod_lo} == 16'h03A8, "R10 hold", {16'd0, prod_hi, prod_lo}, 32'h03A8);

    // R9: second start while busy is dropped
    @(negedge clk);
    start = 1'b1; op_a = 8'h05; op_b = 8'h07; mode = 3'b000;
    @(negedge clk);
    op_a = 8'hFF; op_b = 8'hFF;  // start still high, unit busy
    @(negedge clk);
    start = 1'b0;
    check(done && {prod_hi, prod_lo} == 16'h0023, "R9 first result",
          {15'd0, done, prod_hi, prod_lo}, 32'h0001_0023);
    @(negedge clk);
    check(done == 1'b0, "R9 no second done", {31'd0, done}, 32'd0);
    check({prod_hi, prod_lo} == 16'h0023, "R9 result kept",
          {16'd0, prod_hi, prod_lo}, 32'h0023);

    // Sweep: all eight mode codes, every op_a, twelve op_b values
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 12; k++) begin
          run_op(8'(a), bpick(k), 3'(m));
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule